// File: doc/BRIEF.md
# Dual-Side Mailbox Register Bank

The mailbox bank lets an embedded processor and a PCIe host exchange small control words without a shared memory. Each side has its own simple register port with 32-bit data and byte addresses, and each side owns fifteen writable words. Whatever one side writes shows up, one cycle later, in a read-only window of the other side's address space. Neither side can overwrite the other's data.

A doorbell word on the processor side drives an interrupt request line towards the host. The host answers with a single-cycle acknowledge pulse. That pulse withdraws the request, clears the doorbell word and sets a flag the processor can read back. The processor rearms the handshake by writing the doorbell again. Both ports share one clock and accept a request in every cycle.

Top module: `mbox_bank`

## Requirements
- R1: After reset every word on both sides reads as zero and `host_irq_req` is low.
- R2: Processor words 0 to 13 (byte offset = 4 x index; the two lowest address bits are ignored) read back the last value written. `cpu_req_ready` is always high. Read data appears on `cpu_rsp_data` with `cpu_rsp_valid` high in the cycle after the read is accepted. `cpu_rsp_valid` is low in every cycle after a non-read cycle.
- R3: Host words 0 to 14 read back the last value written, with the same timing as R2.
- R4: A processor write to word n (n from 0 to 13) is returned by a host read of word 15+n that is accepted in the next cycle.
- R5: A host write to word n (n from 0 to 14) is returned by a processor read of word 15+n that is accepted in the next cycle.
- R6: Writes to the read-only words (15 to 30 on either side) complete and change nothing.
- R7: Host words 29 and 30, and word indices 31 to 63 on both sides, read as zero, and writes to them are ignored.
- R8: A nonzero write to processor word 14 raises `host_irq_req` in the next cycle and keeps it high. A zero write drops it.
- R9: A `host_irq_ack` pulse while the request is high drops `host_irq_req` in the next cycle, clears processor word 14 and sets bit 0 of processor word 30.
- R10: `host_irq_ack` while no request is pending changes nothing.
- R11: Any write to processor word 14 clears bit 0 of word 30. If that write and an acknowledge arrive in the same cycle, the write wins and the acknowledge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_write | input | 1 | Processor request is a write (1) or a read (0) |
| cpu_req_addr | input | ADDR_W | Processor byte address |
| cpu_req_wdata | input | DATA_W | Processor write data |
| cpu_req_ready | output | 1 | Processor request accepted (always high) |
| cpu_rsp_valid | output | 1 | Processor read data valid |
| cpu_rsp_data | output | DATA_W | Processor read data |
| hst_req_valid | input | 1 | Host request valid |
| hst_req_write | input | 1 | Host request is a write (1) or a read (0) |
| hst_req_addr | input | ADDR_W | Host byte address |
| hst_req_wdata | input | DATA_W | Host write data |
| hst_req_ready | output | 1 | Host request accepted (always high) |
| hst_rsp_valid | output | 1 | Host read data valid |
| hst_rsp_data | output | DATA_W | Host read data |
| host_irq_req | output | 1 | Interrupt request towards the host |
| host_irq_ack | input | 1 | Single-cycle acknowledge from the host |

## Verification
A wrong mirror connection or a wrong decode shows up on the first read of the affected word from the other side, one cycle after the write. The bench reads such words straight after random writes with unaligned low address bits. A stuck or mistimed doorbell shows up on `host_irq_req` at the first sample after the write or the acknowledge. A lost or spurious acknowledge flag shows up on the next read of processor word 30. The bench checks the request line after every operation, so any error in the handshake appears within one cycle of its cause.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // words each side owns (indices 0 .. OWN_CNT-1)
  localparam int unsigned OWN_CNT    = 15;
  // read-only window words (indices OWN_CNT .. OWN_CNT+WIN_CNT-1)
  localparam int unsigned WIN_CNT    = 16;
  // processor words reflected to the host side
  localparam int unsigned CPU_MIRROR = 14;
  // processor doorbell word index
  localparam int unsigned BELL_IDX   = 14;
  // window slot on the processor side that carries the acknowledge flag
  localparam int unsigned ACK_SLOT   = WIN_CNT - 1;

  // word index from a byte address: drop the two byte-lane bits
  function automatic int unsigned word_of(input int unsigned byte_addr);
    return byte_addr >> 2;
  endfunction

  // acknowledge word content
  function automatic logic [31:0] ack_word(input logic flag);
    return {31'd0, flag};
  endfunction
endpackage

// File: rtl/mbox_side.sv
module mbox_side #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RW_CNT = 15,
  parameter int unsigned RO_CNT = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [DATA_W-1:0]              req_wdata,
  output logic                           req_ready,
  output logic                           rsp_valid,
  output logic [DATA_W-1:0]              rsp_data,
  input  logic [RO_CNT-1:0][DATA_W-1:0]  ro_win,
  input  logic [RW_CNT-1:0]              clr_vec,
  output logic [RW_CNT-1:0][DATA_W-1:0]  regs,
  output logic                           wr_stb,
  output logic [ADDR_W-3:0]              wr_idx
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              rd_stb;
  logic              ro_hit;
  logic [DATA_W-1:0] rd_word;

  assign idx       = req_addr[ADDR_W-1:2];
  assign req_ready = 1'b1;
  assign wr_stb    = req_valid & req_write;
  assign rd_stb    = req_valid & ~req_write;
  assign wr_idx    = idx;
  assign ro_hit    = (idx >= IDX_W'(RW_CNT));

  // owned words: write has priority over the clear request
  for (genvar i = 0; i < RW_CNT; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                              regs[i] <= '0;
      else if (wr_stb && idx == IDX_W'(i))     regs[i] <= req_wdata;
      else if (clr_vec[i])                     regs[i] <= '0;
    end
  end

  // read select: owned words, then window, otherwise zero
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < RW_CNT; i++)
      if (idx == IDX_W'(i)) rd_word = regs[i];
    for (int k = 0; k < RO_CNT; k++)
      if (idx == IDX_W'(RW_CNT + k)) rd_word = ro_win[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_stb;
      if (rd_stb) rsp_data <= rd_word;
    end
  end

  // R2
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rsp_valid);
  // R2
  no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rsp_valid);
  // R6
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ro_hit && clr_vec == '0) |=> $stable(regs));
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bell_wr,
  input  logic [DATA_W-1:0] bell_wdata,
  input  logic [DATA_W-1:0] bell_word,
  input  logic              ack_in,
  output logic              irq_req,
  output logic              ack_flag,
  output logic              bell_clr
);
  logic ack_take;

  assign ack_take = ack_in & irq_req & ~bell_wr;
  assign bell_clr = ack_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req  <= 1'b0;
      ack_flag <= 1'b0;
    end else if (bell_wr) begin
      irq_req  <= |bell_wdata;
      ack_flag <= 1'b0;
    end else if (ack_take) begin
      irq_req  <= 1'b0;
      ack_flag <= 1'b1;
    end
  end

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_wr && bell_wdata != '0) |=> irq_req);
  // R8
  irq_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (bell_word != '0));
  // R9
  ack_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (!irq_req && ack_flag && bell_word == '0));
  // R10
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !irq_req && !bell_wr) |=> $stable(ack_flag));
  // R11
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bell_wr |=> !ack_flag);
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_data,
  input  logic              hst_req_valid,
  input  logic              hst_req_write,
  input  logic [ADDR_W-1:0] hst_req_addr,
  input  logic [DATA_W-1:0] hst_req_wdata,
  output logic              hst_req_ready,
  output logic              hst_rsp_valid,
  output logic [DATA_W-1:0] hst_rsp_data,
  output logic              host_irq_req,
  input  logic              host_irq_ack
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [OWN_CNT-1:0][DATA_W-1:0] cpu_regs, hst_regs;
  logic [WIN_CNT-1:0][DATA_W-1:0] cpu_win, hst_win;
  logic [OWN_CNT-1:0]             cpu_clr;
  logic                           cpu_wr_stb, hst_wr_stb;
  logic [IDX_W-1:0]               cpu_wr_idx, hst_wr_idx;
  logic                           bell_wr, bell_clr, ack_flag;

  // cross windows
  for (genvar k = 0; k < WIN_CNT; k++) begin : g_win
    if (k < OWN_CNT) begin : g_cpu_m
      assign cpu_win[k] = hst_regs[k];
    end else begin : g_cpu_a
      assign cpu_win[k] = DATA_W'(ack_word(ack_flag));
    end
    if (k < CPU_MIRROR) begin : g_hst_m
      assign hst_win[k] = cpu_regs[k];
    end else begin : g_hst_z
      assign hst_win[k] = '0;
    end
  end

  for (genvar i = 0; i < OWN_CNT; i++) begin : g_clr
    if (i == BELL_IDX) begin : g_bell
      assign cpu_clr[i] = bell_clr;
    end else begin : g_none
      assign cpu_clr[i] = 1'b0;
    end
  end

  assign bell_wr = cpu_wr_stb && (cpu_wr_idx == IDX_W'(BELL_IDX));

  mbox_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW_CNT(OWN_CNT), .RO_CNT(WIN_CNT)) u_cpu (
    .clk(clk), .rst_n(rst_n),
    .req_valid(cpu_req_valid), .req_write(cpu_req_write),
    .req_addr(cpu_req_addr), .req_wdata(cpu_req_wdata),
    .req_ready(cpu_req_ready), .rsp_valid(cpu_rsp_valid), .rsp_data(cpu_rsp_data),
    .ro_win(cpu_win), .clr_vec(cpu_clr), .regs(cpu_regs),
    .wr_stb(cpu_wr_stb), .wr_idx(cpu_wr_idx)
  );

  mbox_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW_CNT(OWN_CNT), .RO_CNT(WIN_CNT)) u_hst (
    .clk(clk), .rst_n(rst_n),
    .req_valid(hst_req_valid), .req_write(hst_req_write),
    .req_addr(hst_req_addr), .req_wdata(hst_req_wdata),
    .req_ready(hst_req_ready), .rsp_valid(hst_rsp_valid), .rsp_data(hst_rsp_data),
    .ro_win(hst_win), .clr_vec('0), .regs(hst_regs),
    .wr_stb(hst_wr_stb), .wr_idx(hst_wr_idx)
  );

  mbox_doorbell #(.DATA_W(DATA_W)) u_bell (
    .clk(clk), .rst_n(rst_n),
    .bell_wr(bell_wr), .bell_wdata(cpu_req_wdata), .bell_word(cpu_regs[BELL_IDX]),
    .ack_in(host_irq_ack), .irq_req(host_irq_req), .ack_flag(ack_flag),
    .bell_clr(bell_clr)
  );

  // R4
  mirror_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_stb && cpu_wr_idx < IDX_W'(CPU_MIRROR)) |=> hst_win[$past(cpu_wr_idx)] == $past(cpu_req_wdata));
  // R5
  mirror_hst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr_stb && hst_wr_idx < IDX_W'(OWN_CNT)) |=> cpu_win[$past(hst_wr_idx)] == $past(hst_req_wdata));
  // R7
  hst_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_win[WIN_CNT-1] == '0 && hst_win[WIN_CNT-2] == '0);
endmodule

// File: tb/mbox_bank_test.sv
`timescale 1ns/1ps
module mbox_bank_test;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cv = 0, cw = 0, hv = 0, hw = 0, ack = 0;
  logic [AW-1:0] ca = '0, ha = '0;
  logic [DW-1:0] cd = '0, hd = '0;
  logic cr, crv, hr, hrv, irq;
  logic [DW-1:0] crd, hrd;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] cpu_m [15];
  logic [DW-1:0] hst_m [15];
  logic ack_m = 0, irq_m = 0;

  always #2 clk = ~clk;

  mbox_bank #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cv), .cpu_req_write(cw), .cpu_req_addr(ca), .cpu_req_wdata(cd),
    .cpu_req_ready(cr), .cpu_rsp_valid(crv), .cpu_rsp_data(crd),
    .hst_req_valid(hv), .hst_req_write(hw), .hst_req_addr(ha), .hst_req_wdata(hd),
    .hst_req_ready(hr), .hst_rsp_valid(hrv), .hst_rsp_data(hrd),
    .host_irq_req(irq), .host_irq_ack(ack)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_cpu(input int i);
    if (i < 15) return cpu_m[i];
    if (i < 30) return hst_m[i-15];
    if (i == 30) return {31'd0, ack_m};
    return '0;
  endfunction

  function automatic logic [DW-1:0] exp_hst(input int i);
    if (i < 15) return hst_m[i];
    if (i < 29) return cpu_m[i-15];
    return '0;
  endfunction

  function automatic logic [AW-1:0] addr_of(input int i);
    return AW'((i << 2) | ($urandom % 4));
  endfunction

  function automatic void model_cpu_wr(input int i, input logic [DW-1:0] d);
    if (i < 15) begin
      cpu_m[i] = d;
      if (i == 14) begin ack_m = 0; irq_m = (d != 0); end
    end
  endfunction

  function automatic void model_ack();
    if (irq_m) begin ack_m = 1; irq_m = 0; cpu_m[14] = '0; end
  endfunction

  task automatic cpu_wr(input int i, input logic [DW-1:0] d);
    cv = 1; cw = 1; ca = addr_of(i); cd = d;
    @(negedge clk); cv = 0; cw = 0;
    model_cpu_wr(i, d);
  endtask

  task automatic hst_wr(input int i, input logic [DW-1:0] d);
    hv = 1; hw = 1; ha = addr_of(i); hd = d;
    @(negedge clk); hv = 0; hw = 0;
    if (i < 15) hst_m[i] = d;
  endtask

  task automatic cpu_rd(input int i, input string req);
    cv = 1; cw = 0; ca = addr_of(i);
    @(negedge clk); cv = 0;
    check(req, {31'd0, crv}, 32'd1);
    check(req, crd, exp_cpu(i));
  endtask

  task automatic hst_rd(input int i, input string req);
    hv = 1; hw = 0; ha = addr_of(i);
    @(negedge clk); hv = 0;
    check(req, {31'd0, hrv}, 32'd1);
    check(req, hrd, exp_hst(i));
  endtask

  task automatic pulse_ack();
    ack = 1; @(negedge clk); ack = 0;
    model_ack();
  endtask

  task automatic chk_irq(input string req);
    check(req, {31'd0, irq}, {31'd0, irq_m});
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 15; i++) begin cpu_m[i] = '0; hst_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk_irq("R1 irq");
    cpu_rd(0, "R1 cpu0"); cpu_rd(14, "R1 cpu14"); cpu_rd(30, "R1 cpu30");
    hst_rd(3, "R1 hst3"); hst_rd(20, "R1 hst20");
    // R2 ready and idle response
    check("R2 ready", {30'd0, cr, hr}, 32'd3);
    check("R2 idle rsp", {31'd0, crv}, 32'd0);
    // R2 / R3 readback at the range ends
    cpu_wr(0, 32'hDEAD_0000); cpu_wr(13, 32'h1313_1313);
    cpu_rd(0, "R2 cpu0"); cpu_rd(13, "R2 cpu13");
    hst_wr(0, 32'hA5A5_0001); hst_wr(14, 32'h0E0E_0E0E);
    hst_rd(0, "R3 hst0"); hst_rd(14, "R3 hst14");
    // R4 mirror read on the very next cycle
    cpu_wr(5, 32'h0000_5555); hst_rd(20, "R4 next-cycle mirror");
    hst_rd(28, "R4 cpu13 mirror");
    // R5 mirror read on the very next cycle
    hst_wr(7, 32'h7777_0007); cpu_rd(22, "R5 next-cycle mirror");
    cpu_rd(29, "R5 hst14 mirror");
    // R6 read-only writes ignored
    cpu_wr(20, 32'hBAD0_0020); cpu_rd(20, "R6 cpu ro");
    hst_wr(16, 32'hBAD0_0016); hst_rd(16, "R6 hst ro");
    cpu_wr(30, 32'hFFFF_FFFF); cpu_rd(30, "R6 cpu ack ro");
    // R7 padding and unmapped words
    hst_wr(29, 32'h1); hst_wr(30, 32'h2);
    hst_rd(29, "R7 hst29"); hst_rd(30, "R7 hst30");
    cpu_wr(40, 32'h4040_4040); cpu_rd(40, "R7 cpu40"); hst_rd(63, "R7 hst63");
    // R10 acknowledge with nothing pending
    pulse_ack(); cpu_rd(30, "R10 idle ack"); chk_irq("R10 irq");
    // R8 raise and hold
    cpu_wr(14, 32'h0000_0100); chk_irq("R8 raise");
    repeat (3) @(negedge clk); chk_irq("R8 hold");
    cpu_wr(14, 32'h0); chk_irq("R8 zero write");
    // R9 handshake
    cpu_wr(14, 32'h0000_0003);
    pulse_ack(); chk_irq("R9 drop");
    cpu_rd(14, "R9 bell cleared"); cpu_rd(30, "R9 ack set");
    // R11 rearm clears ack flag
    cpu_wr(14, 32'h0000_0009); cpu_rd(30, "R11 ack cleared"); chk_irq("R11 irq");
    // R11 same-cycle write and acknowledge: write wins
    cv = 1; cw = 1; ca = addr_of(14); cd = 32'h0000_00AA; ack = 1;
    @(negedge clk); cv = 0; cw = 0; ack = 0;
    model_cpu_wr(14, 32'h0000_00AA);
    chk_irq("R11 collide irq");
    cpu_rd(30, "R11 collide ack"); cpu_rd(14, "R11 collide bell");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      int idx;
      logic [DW-1:0] d;
      op = int'($urandom % 6);
      idx = int'($urandom % 40);
      d = ($urandom % 4 == 0) ? '0 : $urandom;
      case (op)
        0: cpu_wr(idx, d);
        1: hst_wr(idx, d);
        2: cpu_rd(idx, "R4 R5 random cpu read");
        3: hst_rd(idx, "R4 R5 random hst read");
        4: pulse_ack();
        default: cpu_wr(14, d);
      endcase
      chk_irq("R8 R9 random irq");
    end

    summary();
    $finish;
  end
endmodule